// File: doc/BRIEF.md
# Local Interrupt Timer

This block is the countdown timer of a per-processor interrupt controller. Software programs three things: a timer entry holding an interrupt vector, a mask bit and a periodic/one-shot mode bit; a 4-bit divide code that selects a power-of-two prescale ratio for the system clock; and an initial count. Writing the initial count starts the count. The current count can be read at any time on a port.

When the count expires, the block raises a one-cycle interrupt request that carries the programmed vector, unless the entry is masked. In periodic mode the count reloads and the request repeats. In one-shot mode the count stays at zero and the timer fires once. While the entry is masked the count keeps running but no request is raised. A zero initial count never produces a request.

Top module: `loc_irq_timer`

## Requirements
- R1: After reset the current count reads 0, no request is raised, the timer entry is masked with one-shot mode and vector 0, and the prescale ratio is 1 until a divide code is written.
- R2: The divide code is written with `wr_sel`=1 in `wr_data[3:0]`. Bits 3, 1 and 0 form v = {b3,b1,b0}; bit 2 is ignored. Values v = 0..6 select a ratio of 2^(v+1) (2 to 128), and v = 7 selects a ratio of 1.
- R3: Writing the initial count (`wr_sel`=2) restarts both the count and the prescaler. After m clock edges the number of elapsed ticks is t = floor(m / ratio).
- R4: In one-shot mode the current count reads initial count minus t while t is below the initial count, and then reads 0.
- R5: In periodic mode the current count reads initial count minus (t mod (initial count + 1)).
- R6: The timer entry is written with `wr_sel`=0: vector in bits [7:0], mask in bit 16, periodic in bit 17. An unmasked periodic timer pulses `irq_pulse` for one cycle, with `irq_vector` equal to the vector, on each tick where t is a nonzero multiple of (initial count + 1). An unmasked one-shot timer pulses once, on the tick where t = initial count + 1.
- R7: A request is raised only if the mask bit is clear at the expiry tick. Masking does not stop the count, and clearing the mask later restores requests at the expiries that follow.
- R8: An initial count of 0 never raises a request in either mode, and the count reads 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Active-low synchronous reset |
| wr_en | input | 1 | Register write strobe |
| wr_sel | input | 2 | Register select: 0 timer entry, 1 divide code, 2 initial count |
| wr_data | input | CNT_W (32) | Write data |
| cur_count | output | CNT_W (32) | Current count |
| irq_pulse | output | 1 | One-cycle interrupt request |
| irq_vector | output | VEC_W (8) | Vector that goes with `irq_pulse` |

## Verification
The count and request outputs are compared, edge by edge, against a tick model computed arithmetically from the elapsed clock edges. The model is run at ratios 1, 2, 8 and 128 in both modes. Divide codes that differ only in the ignored bit, together with the code that maps to ratio 1, separate a correct decode from one that reads bit 2 or handles v = 7 the ordinary way. Small initial counts, including 0 and 1, expose off-by-one errors in the reload length and the one-shot expiry tick. A mask bit set or cleared partway through a count shows that the count keeps running while masked and that the mask is sampled at the expiry tick itself.

// File: rtl/loc_irq_timer_pkg.sv
package loc_irq_timer_pkg;

    // Register select codes
    typedef enum logic [1:0] {
        SEL_ENTRY = 2'd0,
        SEL_DIV   = 2'd1,
        SEL_INIT  = 2'd2,
        SEL_NONE  = 2'd3
    } wsel_e;

    localparam int SHIFT_W = 3;

    // Divide code -> shift: {b3,b1,b0} plus one, wrapping 7 to 0
    function automatic logic [SHIFT_W-1:0] div_to_shift(input logic [3:0] code);
        logic [SHIFT_W-1:0] v;
        v = {code[3], code[1:0]};
        return v + 3'd1;
    endfunction

endpackage

// File: rtl/loc_irq_prescaler.sv
module loc_irq_prescaler #(
    parameter int SHIFT_W = 3,
    localparam int PRE_W  = (1 << SHIFT_W) - 1
) (
    input  logic               clk,
    input  logic               rst_n,
    input  logic               restart,
    input  logic [SHIFT_W-1:0] shift,
    output logic               tick
);
    typedef struct packed {
        logic [PRE_W-1:0] pre;
    } pre_state_t;

    pre_state_t st_d, st_q;
    logic [PRE_W:0]   one_hot;
    logic [PRE_W-1:0] lim;

    always_comb begin
        one_hot = {{PRE_W{1'b0}}, 1'b1} << shift;
        lim     = one_hot[PRE_W-1:0] - {{(PRE_W-1){1'b0}}, 1'b1};
        tick    = !restart && (st_q.pre >= lim);
        st_d    = st_q;
        if (restart || tick) begin
            st_d.pre = '0;
        end else begin
            st_d.pre = st_q.pre + 1'b1;
        end
    end

    always_ff @(posedge clk) begin
        if (!rst_n) st_q <= '0;
        else        st_q <= st_d;
    end

    // R3: a restart leaves the prescaler at zero
    restart_clears_chk: assert property (@(posedge clk) disable iff (!rst_n)
        restart |=> (st_q.pre == '0));

endmodule

// File: rtl/loc_irq_counter.sv
module loc_irq_counter #(
    parameter int CNT_W = 32
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             load,
    input  logic [CNT_W-1:0] load_val,
    input  logic             tick,
    input  logic             periodic,
    output logic [CNT_W-1:0] count,
    output logic             expire
);
    typedef struct packed {
        logic [CNT_W-1:0] cnt;
        logic [CNT_W-1:0] init;
        logic             armed;
    } cnt_state_t;

    cnt_state_t st_d, st_q;
    logic at_zero;

    always_comb begin
        st_d    = st_q;
        at_zero = (st_q.cnt == '0);
        expire  = !load && tick && st_q.armed && at_zero;
        if (load) begin
            st_d.cnt   = load_val;
            st_d.init  = load_val;
            st_d.armed = (load_val != '0);
        end else if (tick) begin
            if (!at_zero) begin
                st_d.cnt = st_q.cnt - 1'b1;
            end else if (st_q.armed) begin
                if (periodic) st_d.cnt = st_q.init;
                else          st_d.armed = 1'b0;
            end
        end
    end

    always_ff @(posedge clk) begin
        if (!rst_n) st_q <= '0;
        else        st_q <= st_d;
    end

    assign count = st_q.cnt;

    // R3
    count_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (!load && !tick) |=> $stable(st_q.cnt));

    // R4
    oneshot_no_rise_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (!load && !periodic) |=> (st_q.cnt <= $past(st_q.cnt)));

    // R5
    periodic_reload_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (expire && periodic) |=> (st_q.cnt == st_q.init));

    // R8
    zero_never_fires_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (st_q.init == '0) |-> !expire);

endmodule

// File: rtl/loc_irq_timer.sv
module loc_irq_timer
    import loc_irq_timer_pkg::*;
#(
    parameter int CNT_W    = 32,
    parameter int VEC_W    = 8,
    parameter int MASK_BIT = 16,
    parameter int PER_BIT  = 17
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             wr_en,
    input  logic [1:0]       wr_sel,
    input  logic [CNT_W-1:0] wr_data,
    output logic [CNT_W-1:0] cur_count,
    output logic             irq_pulse,
    output logic [VEC_W-1:0] irq_vector
);
    typedef struct packed {
        logic [VEC_W-1:0]   vec;
        logic               mask;
        logic               per;
        logic [SHIFT_W-1:0] shift;
        logic               irq;
        logic [VEC_W-1:0]   irq_vec;
    } top_state_t;

    top_state_t st_d, st_q;
    wsel_e      sel;
    logic       load, tick, expire;

    always_comb begin
        sel  = wsel_e'(wr_sel);
        load = wr_en && (sel == SEL_INIT);
        st_d = st_q;
        st_d.irq     = expire && !st_q.mask;
        st_d.irq_vec = (expire && !st_q.mask) ? st_q.vec : '0;
        if (wr_en && sel == SEL_ENTRY) begin
            st_d.vec  = wr_data[VEC_W-1:0];
            st_d.mask = wr_data[MASK_BIT];
            st_d.per  = wr_data[PER_BIT];
        end
        if (wr_en && sel == SEL_DIV) begin
            st_d.shift = div_to_shift(wr_data[3:0]);
        end
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            st_q      <= '0;
            st_q.mask <= 1'b1;
        end else begin
            st_q <= st_d;
        end
    end

    loc_irq_prescaler #(.SHIFT_W(SHIFT_W)) u_pre (
        .clk    (clk),
        .rst_n  (rst_n),
        .restart(load),
        .shift  (st_q.shift),
        .tick   (tick)
    );

    loc_irq_counter #(.CNT_W(CNT_W)) u_cnt (
        .clk     (clk),
        .rst_n   (rst_n),
        .load    (load),
        .load_val(wr_data),
        .tick    (tick),
        .periodic(st_q.per),
        .count   (cur_count),
        .expire  (expire)
    );

    assign irq_pulse  = st_q.irq;
    assign irq_vector = st_q.irq_vec;

    // R7
    irq_unmasked_chk: assert property (@(posedge clk) disable iff (!rst_n)
        irq_pulse |-> $past(!st_q.mask));

    // R6
    irq_single_cycle_chk: assert property (@(posedge clk) disable iff (!rst_n)
        irq_pulse |=> !irq_pulse);

    // R6
    irq_vector_chk: assert property (@(posedge clk) disable iff (!rst_n)
        irq_pulse |-> (irq_vector == $past(st_q.vec)));

endmodule

// File: tb/loc_irq_timer_tb.sv
module loc_irq_timer_tb;
    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        wr_en = 1'b0;
    logic [1:0]  wr_sel = 2'd3;
    logic [31:0] wr_data = '0;
    logic [31:0] cur_count;
    logic        irq_pulse;
    logic [7:0]  irq_vector;

    int checks = 0;
    int errors = 0;
    bit done = 1'b0;

    always #5 clk = ~clk;

    loc_irq_timer u_dut (
        .clk(clk), .rst_n(rst_n), .wr_en(wr_en), .wr_sel(wr_sel),
        .wr_data(wr_data), .cur_count(cur_count),
        .irq_pulse(irq_pulse), .irq_vector(irq_vector)
    );

    task automatic chk(input string req, input string what,
                       input longint act, input longint exp);
        checks++;
        if (act != exp) begin
            errors++;
            $display("FAIL %s %s actual %0d expected %0d", req, what, act, exp);
        end
    endtask

    task automatic wr(input logic [1:0] sel, input logic [31:0] data);
        wr_en = 1'b1; wr_sel = sel; wr_data = data;
        @(posedge clk); #1;
        wr_en = 1'b0; wr_sel = 2'd3;
    endtask

    function automatic logic [31:0] entry(input bit per, input bit msk,
                                          input logic [7:0] vec);
        return (32'(per) << 17) | (32'(msk) << 16) | 32'(vec);
    endfunction

    // cfg=0: keep current entry/divide; m0 then gives the mask in force
    task automatic run_case(input bit cfg, input logic [3:0] dcode, input int s,
                            input bit per, input bit m0, input int tog,
                            input bit m1, input logic [7:0] vec,
                            input longint init, input int n,
                            input string creq, input string ireq);
        if (cfg) begin
            wr(2'd0, entry(per, m0, vec));
            wr(2'd1, {28'd0, dcode});
        end
        wr(2'd2, 32'(init));
        chk(creq, "count at load", longint'(cur_count), init);
        for (int m = 1; m <= n; m++) begin
            longint t;
            longint ecnt;
            bit     eirq;
            bit     mk;
            bit     tedge;
            if (m == tog) begin
                wr_en = 1'b1; wr_sel = 2'd0; wr_data = entry(per, m1, vec);
            end
            @(posedge clk); #1;
            wr_en = 1'b0; wr_sel = 2'd3;
            t     = longint'(m) >> s;
            tedge = ((longint'(m) % (longint'(1) << s)) == 0);
            mk    = (tog > 0 && m > tog) ? m1 : m0;
            if (per) ecnt = init - (t % (init + 1));
            else     ecnt = (t >= init) ? 0 : init - t;
            if (per) eirq = (init != 0) && tedge && (t % (init + 1) == 0);
            else     eirq = (init != 0) && tedge && (t == init + 1);
            eirq = eirq && !mk;
            chk(creq, "count", longint'(cur_count), ecnt);
            chk(ireq, "irq", longint'(irq_pulse), longint'(eirq));
            if (eirq) chk("R6", "vector", longint'(irq_vector), longint'(vec));
        end
    endtask

    initial begin
        repeat (3) @(posedge clk);
        #1;
        chk("R1", "reset count", longint'(cur_count), 0);
        chk("R1", "reset irq", longint'(irq_pulse), 0);
        rst_n = 1'b1;
        @(posedge clk); #1;
        // R1: reset entry masked one-shot, ratio 1
        run_case(0, 4'h0, 0, 0, 1, 0, 0, 8'h00, 3, 8, "R1", "R1");
        // R2: code 1011 -> ratio 1; R5/R6 periodic
        run_case(1, 4'b1011, 0, 1, 0, 0, 0, 8'h31, 4, 30, "R5", "R6");
        // R2: code 0000 -> ratio 2, periodic
        run_case(1, 4'b0000, 1, 1, 0, 0, 0, 8'h42, 3, 40, "R2", "R6");
        // R2: bit 2 ignored, 0100 -> ratio 2, one-shot R4
        run_case(1, 4'b0100, 1, 0, 0, 0, 0, 8'h55, 5, 20, "R4", "R6");
        // R2: code 0110 -> ratio 8, one-shot
        run_case(1, 4'b0110, 3, 0, 0, 0, 0, 8'h66, 2, 40, "R2", "R6");
        // R2/R3: code 1010 -> ratio 128, periodic
        run_case(1, 4'b1010, 7, 1, 0, 0, 0, 8'h7e, 5, 2000, "R3", "R6");
        // ratio 128, one-shot
        run_case(1, 4'b1010, 7, 0, 0, 0, 0, 8'h13, 3, 700, "R4", "R6");
        // R8: zero counts
        run_case(1, 4'b1011, 0, 1, 0, 0, 0, 8'h21, 0, 20, "R8", "R8");
        run_case(1, 4'b1011, 0, 0, 0, 0, 0, 8'h22, 0, 20, "R8", "R8");
        // periodic init 1 at ratio 1
        run_case(1, 4'b1011, 0, 1, 0, 0, 0, 8'h23, 1, 12, "R5", "R6");
        // R7: mask set mid-count, later cleared
        run_case(1, 4'b1011, 0, 1, 0, 10, 1, 8'h81, 3, 24, "R7", "R7");
        run_case(1, 4'b1011, 0, 1, 1, 9, 0, 8'h82, 3, 24, "R7", "R7");
        // R7: mask written at the expiry edge itself
        run_case(1, 4'b1011, 0, 1, 0, 4, 1, 8'h83, 3, 12, "R7", "R7");
        run_case(1, 4'b1011, 0, 0, 1, 3, 0, 8'h84, 6, 12, "R7", "R7");
        // R3: restart mid-count without reset, ratio 8
        run_case(1, 4'b0110, 3, 1, 0, 0, 0, 8'h90, 4, 13, "R3", "R6");
        run_case(0, 4'h0, 3, 1, 0, 0, 0, 8'h90, 2, 60, "R3", "R6");
        done = 1'b1;
        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    end

    initial begin
        #(200000 * 10);
        if (!done) begin
            checks++;
            errors++;
            $display("FAIL watchdog actual hung expected done");
            $display("Simulation finished: %0d checks, %0d errors", checks, errors);
            $finish;
        end
    end

endmodule